// File: doc/BRIEF.md
# Serial Tuning Register Interface

This block is the register front end of a radio tuning synthesizer. A host controller writes it over a three-wire serial link made of a serial clock, a data line and an active-high enable. Every transfer carries one 8-bit word. The two bits sent first are an address that selects one of four register words, and the six bits that follow are the payload. The block checks the framing of each transfer. It commits the word only after enable drops, and only if the word was complete.

The committed state has three parts. The first is the operating mode, decoded into one flag per mode. The second is the reference-step select and the charge-pump gain code. The third is the pair of divider values for the synthesizer counters: an 8-bit main value PC and a 6-bit swallow value SC. The divider values are double-buffered. A new PC value sits in a staging register until the SC word is committed, so the counters always receive a matched pair. After reset everything is zero, which is standby. In standby a stop output tells the oscillator, the reference divider and the input dividers to halt, while every register keeps its contents.

Top module: `tune_serial_regs`

## Requirements
- R1: After reset, `pc_o` and `sc_o` are zero, `cp_gain_o` and `step_coarse_o` are zero, and `stop_o` is 1 while the other three mode flags are 0.
- R2: A word is shifted in most-significant bit first on rising serial clock edges. Bits [7:6] select the target: 00 loads PC[5:0] staging from bits [5:0], 01 loads the control word, 10 loads PC[7:6] staging from bits [1:0], and 11 loads SC from bits [5:0].
- R3: A transfer is committed only if exactly 8 rising serial clock edges occur while enable is high. A transfer with fewer or more edges changes no output.
- R4: No output changes while enable is high, even once 8 bits have arrived. A valid word takes effect only after enable falls.
- R5: Writing either PC staging word leaves `pc_o` unchanged. Committing the SC word updates `sc_o` and, in the same cycle, loads `pc_o` from the two staging parts.
- R6: Control bits [1:0] select the mode as {bit1, bit0}: 00 standby (`stop_o`), 10 FM (`fm_o`), 01 AM swallow (`am_swallow_o`), 11 AM direct (`am_direct_o`). Exactly one of the four flags is high at any time.
- R7: Control bit 2 drives `step_coarse_o`, and control bits [4:3] drive `cp_gain_o`.
- R8: Entering standby keeps `pc_o`, `sc_o` and the staging registers. Writes are still accepted during standby, and leaving standby resumes with the stored values.
- R9: Words may arrive in any order and in any number. The latest write to a word wins, and an SC commit always uses the most recent staged PC parts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from host (asynchronous) |
| ser_dat_i | input | 1 | Serial data from host (asynchronous) |
| ser_en_i | input | 1 | Transfer enable, active high (asynchronous) |
| stop_o | output | 1 | Standby: stop oscillator, reference and input dividers |
| fm_o | output | 1 | FM mode active |
| am_swallow_o | output | 1 | AM swallow-counter mode active |
| am_direct_o | output | 1 | AM direct-divider mode active |
| step_coarse_o | output | 1 | Reference step select |
| cp_gain_o | output | 2 | Charge-pump current code |
| pc_o | output | PC_W | Committed main divider value |
| sc_o | output | SC_W | Committed swallow divider value |

## Verification
The bench uses the default parameters: 8-bit words, a 2-stage input synchronizer, an 8-bit PC and a 6-bit SC. With these values PC is split across two staging words, so the bench can reach the staging path from both halves, in every order relative to the SC commit. The serial clock is slow against the system clock, which lets the bench sample the outputs after exactly 8 edges but before enable falls. Frames of 7 and 9 edges exercise the framing check on either side of the valid count.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    WA_PC_LO = 2'b00,
    WA_CTRL  = 2'b01,
    WA_PC_HI = 2'b10,
    WA_SC    = 2'b11
  } word_addr_e;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'b00,
    MODE_AMSW  = 2'b01,
    MODE_FM    = 2'b10,
    MODE_AMDIR = 2'b11
  } mode_e;

  // control payload field positions
  localparam int CTL_MODE_LSB = 0;
  localparam int CTL_STEP_BIT = 2;
  localparam int CTL_CP_LSB   = 3;
  localparam int CP_W         = 2;
endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else if (s == 0) pipe[s] <= d_i;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/tsr_framer.sv
module tsr_framer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sen_s,
  output logic              commit_v,
  output logic [WORD_W-1:0] commit_word
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic              sclk_d;
  logic              sen_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;

  wire sen_rise  = sen_s & ~sen_d;
  wire sen_fall  = ~sen_s & sen_d;
  wire sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d      <= 1'b0;
      sen_d       <= 1'b0;
      bit_cnt     <= '0;
      shreg       <= '0;
      commit_v    <= 1'b0;
      commit_word <= '0;
    end else begin
      sclk_d   <= sclk_s;
      sen_d    <= sen_s;
      commit_v <= 1'b0;
      if (sen_rise) begin
        bit_cnt <= '0;
      end else if (sen_s && sclk_rise) begin
        shreg <= {shreg[WORD_W-2:0], sdat_s};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sen_fall && (bit_cnt == CNT_FULL)) begin
        commit_v    <= 1'b1;
        commit_word <= shreg;
      end
    end
  end
endmodule

// File: rtl/tsr_regbank.sv
module tsr_regbank
  import tune_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int PC_W   = 8,
  parameter int SC_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_v,
  input  logic [WORD_W-1:0] commit_word,
  output logic              stop_o,
  output logic              fm_o,
  output logic              am_swallow_o,
  output logic              am_direct_o,
  output logic              step_coarse_o,
  output logic [CP_W-1:0]   cp_gain_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [SC_W-1:0]   sc_o
);
  localparam int DATA_W  = WORD_W - ADDR_W;
  localparam int PC_HI_W = PC_W - DATA_W;

  word_addr_e        waddr;
  logic [DATA_W-1:0] wdata;
  mode_e             wmode;
  logic [DATA_W-1:0]  pc_lo_stg;
  logic [PC_HI_W-1:0] pc_hi_stg;

  assign waddr = word_addr_e'(commit_word[WORD_W-1 -: ADDR_W]);
  assign wdata = commit_word[DATA_W-1:0];
  assign wmode = mode_e'(wdata[CTL_MODE_LSB +: 2]);

  logic unused_payload;
  assign unused_payload = ^wdata[DATA_W-1:CTL_CP_LSB+CP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_lo_stg     <= '0;
      pc_hi_stg     <= '0;
      pc_o          <= '0;
      sc_o          <= '0;
      stop_o        <= 1'b1;
      fm_o          <= 1'b0;
      am_swallow_o  <= 1'b0;
      am_direct_o   <= 1'b0;
      step_coarse_o <= 1'b0;
      cp_gain_o     <= '0;
    end else if (commit_v) begin
      unique case (waddr)
        WA_PC_LO: pc_lo_stg <= wdata;
        WA_PC_HI: pc_hi_stg <= wdata[PC_HI_W-1:0];
        WA_SC: begin
          sc_o <= wdata[SC_W-1:0];
          pc_o <= {pc_hi_stg, pc_lo_stg};
        end
        WA_CTRL: begin
          stop_o        <= (wmode == MODE_STBY);
          fm_o          <= (wmode == MODE_FM);
          am_swallow_o  <= (wmode == MODE_AMSW);
          am_direct_o   <= (wmode == MODE_AMDIR);
          step_coarse_o <= wdata[CTL_STEP_BIT];
          cp_gain_o     <= wdata[CTL_CP_LSB +: CP_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tune_serial_regs.sv
module tune_serial_regs
  import tune_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int PC_W        = 8,
  parameter int SC_W        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_clk_i,
  input  logic            ser_dat_i,
  input  logic            ser_en_i,
  output logic            stop_o,
  output logic            fm_o,
  output logic            am_swallow_o,
  output logic            am_direct_o,
  output logic            step_coarse_o,
  output logic [1:0]      cp_gain_o,
  output logic [PC_W-1:0] pc_o,
  output logic [SC_W-1:0] sc_o
);
  logic [2:0]        pins_s;
  logic              sclk_s;
  logic              sdat_s;
  logic              sen_s;
  logic              commit_v;
  logic [WORD_W-1:0] commit_word;

  tsr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ser_en_i, ser_dat_i, ser_clk_i}),
    .q_o (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign sdat_s = pins_s[1];
  assign sen_s  = pins_s[2];

  tsr_framer #(.WORD_W(WORD_W)) u_framer (
    .clk         (clk),
    .rst         (rst),
    .sclk_s      (sclk_s),
    .sdat_s      (sdat_s),
    .sen_s       (sen_s),
    .commit_v    (commit_v),
    .commit_word (commit_word)
  );

  tsr_regbank #(.WORD_W(WORD_W), .PC_W(PC_W), .SC_W(SC_W)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .commit_v      (commit_v),
    .commit_word   (commit_word),
    .stop_o        (stop_o),
    .fm_o          (fm_o),
    .am_swallow_o  (am_swallow_o),
    .am_direct_o   (am_direct_o),
    .step_coarse_o (step_coarse_o),
    .cp_gain_o     (cp_gain_o),
    .pc_o          (pc_o),
    .sc_o          (sc_o)
  );
endmodule

// File: rtl/tune_serial_regs_chk.sv
module tune_serial_regs_chk #(
  parameter int PC_W = 8,
  parameter int SC_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            sen_s,
  input logic            commit_v,
  input logic [1:0]      commit_addr,
  input logic            stop_o,
  input logic            fm_o,
  input logic            am_swallow_o,
  input logic            am_direct_o,
  input logic [PC_W-1:0] pc_o,
  input logic [SC_W-1:0] sc_o
);
  AST_RESET_STANDBY: assert property (@(posedge clk)
    $past(rst) |-> (stop_o && !fm_o && pc_o == '0 && sc_o == '0)); // R1

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
    $onehot({stop_o, fm_o, am_swallow_o, am_direct_o})); // R6

  AST_COMMIT_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
    commit_v |-> !$past(sen_s)); // R4

  AST_PC_ON_SC_ONLY: assert property (@(posedge clk) disable iff (rst)
    (pc_o != $past(pc_o)) |-> ($past(commit_v) && $past(commit_addr) == 2'b11)); // R5
endmodule

bind tune_serial_regs tune_serial_regs_chk #(.PC_W(PC_W), .SC_W(SC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sen_s        (sen_s),
  .commit_v     (commit_v),
  .commit_addr  (commit_word[WORD_W-1 -: 2]),
  .stop_o       (stop_o),
  .fm_o         (fm_o),
  .am_swallow_o (am_swallow_o),
  .am_direct_o  (am_direct_o),
  .pc_o         (pc_o),
  .sc_o         (sc_o)
);

// File: tb/tune_serial_regs_bench.sv
module tune_serial_regs_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, sen = 1'b0;
  logic stop_o, fm_o, am_swallow_o, am_direct_o, step_coarse_o;
  logic [1:0] cp_gain_o;
  logic [7:0] pc_o;
  logic [5:0] sc_o;

  always #4 clk = ~clk;  // 125 MHz

  tune_serial_regs u_tune_serial_regs (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_en_i(sen),
    .stop_o(stop_o), .fm_o(fm_o), .am_swallow_o(am_swallow_o),
    .am_direct_o(am_direct_o), .step_coarse_o(step_coarse_o),
    .cp_gain_o(cp_gain_o), .pc_o(pc_o), .sc_o(sc_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [20:0] exp_q[$];
  string tag_q[$];
  event chk_ev;

  // reference model state
  logic [1:0] m_mode = 2'b00;
  logic m_step = 1'b0;
  logic [1:0] m_cp = 2'b00;
  logic [5:0] m_pclo = '0;
  logic [1:0] m_pchi = '0;
  logic [7:0] m_pc = '0;
  logic [5:0] m_sc = '0;

  function automatic logic [20:0] model_vec();
    return {m_mode == 2'b00, m_mode == 2'b10, m_mode == 2'b01, m_mode == 2'b11,
            m_step, m_cp, m_pc, m_sc};
  endfunction

  task automatic expect_now(input string tag);
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
    -> chk_ev;
    repeat (3) @(negedge clk);
  endtask

  task automatic apply_model(input logic [7:0] b);
    case (b[7:6])
      2'b00: m_pclo = b[5:0];
      2'b10: m_pchi = b[1:0];
      2'b01: begin m_mode = b[1:0]; m_step = b[2]; m_cp = b[4:3]; end
      default: begin m_sc = b[5:0]; m_pc = {m_pchi, m_pclo}; end
    endcase
  endtask

  task automatic send(input logic [7:0] b, input int edges, input bit mid, input string tag);
    @(negedge clk) sen = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < edges; i++) begin
      sdat = (i < 8) ? b[7-i] : 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    if (mid) expect_now({tag, " mid-frame"});
    sen = 1'b0;
    repeat (8) @(negedge clk);
    if (edges == 8) apply_model(b);
    expect_now(tag);
  endtask

  // monitor: pops expected items and compares against outputs
  initial begin
    forever begin
      @(chk_ev);
      @(negedge clk);
      begin
        logic [20:0] act, exp;
        string t;
        act = {stop_o, fm_o, am_swallow_o, am_direct_o, step_coarse_o, cp_gain_o, pc_o, sc_o};
        exp = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (act !== exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    expect_now("R1 reset state");
    send(8'h42, 8, 1'b0, "R2 R6 control word selects FM");
    send(8'h2A, 8, 1'b0, "R5 R2 PC low staged, pc_o unchanged");
    send(8'h82, 8, 1'b0, "R5 PC high staged, pc_o unchanged");
    send(8'hD5, 8, 1'b0, "R5 SC commit loads PC and SC");
    send(8'hFF, 7, 1'b0, "R3 short frame discarded");
    send(8'hC3, 9, 1'b0, "R3 long frame discarded");
    send(8'hE7, 8, 1'b1, "R4 no change while enable high");
    send(8'h5D, 8, 1'b0, "R6 R7 AM swallow, step and gain");
    send(8'h4B, 8, 1'b0, "R6 R7 AM direct");
    send(8'h50, 8, 1'b0, "R8 standby keeps divider values");
    send(8'h05, 8, 1'b0, "R8 staging write in standby");
    send(8'hC9, 8, 1'b0, "R8 SC commit in standby");
    send(8'h42, 8, 1'b0, "R8 leave standby to FM");
    send(8'hC1, 8, 1'b0, "R9 SC first, staged PC reused");
    send(8'h81, 8, 1'b0, "R9 PC high after SC, pc_o unchanged");
    send(8'hC2, 8, 1'b0, "R9 latest staged values committed");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule